// File: doc/BRIEF.md
# Rotating Register Window Address Mapper

This block turns a logical register number into a physical index for a 224-entry register file. It keeps the current window state and applies it to each access. Two address modes are supported. In window mode the number is an offset from the window base. In based mode the number selects a slot in a rotating sub-area inside the window. Software-pipelined loops use this mode, so that each bundle sees the loop registers shifted by one pair.

The window state has five fields: the window base and window size, which a set-window command writes, and the based-area base, the based-area size and the rotation index, which a set-base command writes. At the end of each bundle, a two-bit advance field and the branch outcome decide whether the rotation index steps forward. An access whose number lies outside the valid range raises an error flag and has its write enable removed. Translation is combinational on the registered state, so an access in a given cycle always sees the state as it was before that cycle's commands.

Top module: `regwin_mapper`

## Requirements
- R1: `phys_idx` is always below 224, because every physical sum is reduced modulo 224.
- R2: In window mode (`lreg_based`=0) register r maps to (r + 2*wbs) mod 224. It is in range only when r < 64 and r < 2*wsz.
- R3: In based mode the rotating size is S = 2*rsz + 2. The local slot is (r + 2*(rsz + 1 - rcur)) mod S, taken as a true non-negative modulus even when rcur > rsz + 1.
- R4: In based mode the physical index is (local + 2*wbs + 2*rbs) mod 224. It is in range only when r < 128, r < 2*wsz and r < S.
- R5: `set_base` writes rcur from `base_word` bits 17:12, rsz from bits 11:6 and rbs from bits 5:0. All other bits are ignored.
- R6: `set_win` writes wsz from `win_lit` bits 11:5 and wbs from `win_base`. All other literal bits are ignored.
- R7: On a cycle with `bundle_end`=1, the step bit is `adv_field`[0] if `branch_taken`=1 and `adv_field`[1] otherwise. When that bit is set, rcur becomes (rcur + 1) mod (rsz + 1). Without `bundle_end`, rcur does not change.
- R8: With `acc_valid`=1, an access that is out of range sets `range_err` and forces `wr_en` low. Otherwise `wr_en` follows `acc_write`. With `acc_valid`=0, both `range_err` and `wr_en` are 0.
- R9: Commands and rotation update the state on the clock edge, and translation in the same cycle uses the old state. When a command and an advance meet on one edge, the rotation acts on the newly written rcur and rsz.
- R10: A synchronous active-low reset clears wbs, wsz, rbs, rsz and rcur to zero, so every access is then out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | The access wants to write |
| lreg_num | input | 7 | Logical register number |
| lreg_based | input | 1 | 1 selects based (rotating) mode, 0 selects window mode |
| set_win | input | 1 | Set-window command |
| win_base | input | 7 | New window base for set-window |
| win_lit | input | 32 | Literal word carrying the window size in bits 11:5 |
| set_base | input | 1 | Set-base command |
| base_word | input | 32 | Control word carrying rcur/rsz/rbs |
| bundle_end | input | 1 | The current bundle completes this cycle |
| branch_taken | input | 1 | The bundle ends with a taken branch |
| adv_field | input | 2 | Advance control: bit 1 applies without a branch, bit 0 with a branch |
| phys_idx | output | 8 | Physical register index |
| range_err | output | 1 | Out-of-range access |
| wr_en | output | 1 | Gated write enable |

## Verification
The hardest state to reach is a based area whose rotation index has run past several wrap points, and in particular one loaded with rcur larger than rsz. In that case the offset term is negative, and the local modulus and the rotation modulus both have to produce the mathematically correct residue. The bench reaches this state in two ways. It steps the index repeatedly under every combination of advance bits and branch outcome. It also loads an index above the area size directly. After every state change it sweeps all 128 register numbers in both modes against an arithmetic model. It also drives a command together with an advance on the same edge.

// File: rtl/regwin_pkg.sv
// Shared types for the register window mapper.
// Assumes the field widths below match the command word layout.
package regwin_pkg;
    localparam int WBS_W = 7;
    localparam int WSZ_W = 7;
    localparam int RB_W  = 6;

    // Bit positions inside the set-base control word and the set-window literal
    localparam int RCUR_LSB = 12;
    localparam int RSZ_LSB  = 6;
    localparam int RBS_LSB  = 0;
    localparam int WSZ_LSB  = 5;

    typedef struct packed {
        logic [WBS_W-1:0] wbs;
        logic [WSZ_W-1:0] wsz;
        logic [RB_W-1:0]  rbs;
        logic [RB_W-1:0]  rsz;
        logic [RB_W-1:0]  rcur;
    } win_state_t;
endpackage

// File: rtl/regwin_state.sv
// Holds the window state. Applies the set-window and set-base commands, then
// applies the end-of-bundle rotation to the result.
// Assumes the commands are sampled on the same edge as bundle_end.
module regwin_state
    import regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_win,
    input  logic [6:0]  win_base,
    input  logic [31:0] win_lit,
    input  logic        set_base,
    input  logic [31:0] base_word,
    input  logic        bundle_end,
    input  logic        branch_taken,
    input  logic [1:0]  adv_field,
    output win_state_t  st
);
    win_state_t loaded;
    win_state_t nxt;
    logic       step;
    logic [RB_W:0] rot_mod;
    logic [RB_W:0] rcur_inc;
    logic       unused_bits;

    assign unused_bits = ^{win_lit[31:WSZ_LSB+WSZ_W], win_lit[WSZ_LSB-1:0],
                           base_word[31:RCUR_LSB+RB_W]};

    // Apply the command loads, then the rotation on top of the loaded values
    always_comb begin
        loaded = st;
        if (set_win) begin
            loaded.wbs = win_base;
            loaded.wsz = win_lit[WSZ_LSB +: WSZ_W];
        end
        if (set_base) begin
            loaded.rcur = base_word[RCUR_LSB +: RB_W];
            loaded.rsz  = base_word[RSZ_LSB +: RB_W];
            loaded.rbs  = base_word[RBS_LSB +: RB_W];
        end
        step     = bundle_end & (branch_taken ? adv_field[0] : adv_field[1]);
        rot_mod  = {1'b0, loaded.rsz} + 1'b1;
        rcur_inc = ({1'b0, loaded.rcur} + 1'b1) % rot_mod;
        nxt      = loaded;
        if (step) nxt.rcur = rcur_inc[RB_W-1:0];
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= nxt;
    end

    // R7: after a rotation step the index is inside the rotating range
    p_rcur_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (st.rcur <= st.rsz));

    // R9: without commands or bundle end the state is held
    p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_win || set_base || bundle_end) |=> (st == $past(st)));

    // R5: set-base writes the size field from bits 11:6
    p_setbase_rsz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_base |=> (st.rsz == $past(base_word[11:6])));

    // R6: set-window writes the size from literal bits 11:5
    p_setwin_wsz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_win |=> (st.wsz == $past(win_lit[11:5])));
endmodule

// File: rtl/regwin_xlate.sv
// Combinational translation from a logical register number to a physical index.
// Assumes each physical sum is below 3*PHYS, which holds for the default
// widths: at most 127 + 254 + 126 = 507, and 507 < 672.
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int PHYS      = 224,
    parameter int WIN_LIMIT = 64,
    parameter int IDX_W     = $clog2(PHYS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  win_state_t       st,
    input  logic [6:0]       lreg,
    input  logic             based,
    output logic [IDX_W-1:0] idx,
    output logic             oob
);
    localparam logic [9:0] P1    = 10'(PHYS);
    localparam logic [9:0] P2    = 10'(2 * PHYS);
    localparam logic [7:0] WLIM8 = 8'(WIN_LIMIT);

    logic [7:0] lr8, two_wbs, two_wsz, two_rbs, rot_size, rc2, rc2m, local_slot;
    logic [9:0] sum, wrapped;

    // Local slot inside the rotating area: (r - 2*rcur) mod S
    always_comb begin
        lr8      = {1'b0, lreg};
        two_wbs  = {st.wbs, 1'b0};
        two_wsz  = {st.wsz, 1'b0};
        two_rbs  = {1'b0, st.rbs, 1'b0};
        rot_size = {1'b0, st.rsz, 1'b0} + 8'd2;
        rc2      = {1'b0, st.rcur, 1'b0};
        rc2m     = rc2 % rot_size;
        local_slot = (lr8 >= rc2m) ? (lr8 - rc2m) : (lr8 + rot_size - rc2m);
    end

    // Physical sum and wrap into the register file
    always_comb begin
        if (based) sum = {2'b0, local_slot} + {2'b0, two_wbs} + {2'b0, two_rbs};
        else       sum = {2'b0, lr8} + {2'b0, two_wbs};
        if (sum >= P2)      wrapped = sum - P2;
        else if (sum >= P1) wrapped = sum - P1;
        else                wrapped = sum;
        idx = IDX_W'(wrapped);
    end

    // Range check for the selected mode
    always_comb begin
        if (based) oob = !((lr8 < two_wsz) && (lr8 < rot_size));
        else       oob = !((lr8 < WLIM8) && (lr8 < two_wsz));
    end

    // R1: the physical index stays inside the file
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx) < PHYS);

    // R3: an in-range based access lands inside the rotating area
    p_local_in_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (based && !oob) |-> (local_slot < rot_size));
endmodule

// File: rtl/regwin_mapper.sv
// Top level of the register window mapper. Holds the window state, translates
// each access and gates its write enable on the range check.
// Assumes one access per cycle, with the commands and the advance coming from
// the bundle now completing.
module regwin_mapper
    import regwin_pkg::*;
#(
    parameter int PHYS      = 224,
    parameter int WIN_LIMIT = 64,
    localparam int IDX_W    = $clog2(PHYS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [6:0]       lreg_num,
    input  logic             lreg_based,
    input  logic             set_win,
    input  logic [6:0]       win_base,
    input  logic [31:0]      win_lit,
    input  logic             set_base,
    input  logic [31:0]      base_word,
    input  logic             bundle_end,
    input  logic             branch_taken,
    input  logic [1:0]       adv_field,
    output logic [IDX_W-1:0] phys_idx,
    output logic             range_err,
    output logic             wr_en
);
    win_state_t st;
    logic       oob;

    regwin_state u_state (
        .clk(clk), .rst_n(rst_n),
        .set_win(set_win), .win_base(win_base), .win_lit(win_lit),
        .set_base(set_base), .base_word(base_word),
        .bundle_end(bundle_end), .branch_taken(branch_taken),
        .adv_field(adv_field), .st(st)
    );

    regwin_xlate #(.PHYS(PHYS), .WIN_LIMIT(WIN_LIMIT), .IDX_W(IDX_W)) u_xlate (
        .clk(clk), .rst_n(rst_n), .st(st),
        .lreg(lreg_num), .based(lreg_based),
        .idx(phys_idx), .oob(oob)
    );

    // Error flag and gated write enable for the current access
    always_comb begin
        range_err = acc_valid & oob;
        wr_en     = acc_valid & acc_write & ~oob;
    end

    // R8: an out-of-range access never writes
    p_err_blocks_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> !wr_en);

    // R8: with no access presented, both outputs stay low
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!range_err && !wr_en));
endmodule

// File: tb/sim_regwin_mapper.sv
`timescale 1ns/1ps
module sim_regwin_mapper;
    logic clk = 0, rst_n = 0;
    logic acc_valid = 0, acc_write = 0, lreg_based = 0;
    logic [6:0] lreg_num = 0, win_base = 0;
    logic set_win = 0, set_base = 0, bundle_end = 0, branch_taken = 0;
    logic [31:0] win_lit = 0, base_word = 0;
    logic [1:0] adv_field = 0;
    logic [7:0] phys_idx;
    logic range_err, wr_en;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_wbs = 0, m_wsz = 0, m_rbs = 0, m_rsz = 0, m_rcur = 0;

    always #2 clk = ~clk;

    regwin_mapper u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .lreg_num(lreg_num), .lreg_based(lreg_based), .set_win(set_win),
        .win_base(win_base), .win_lit(win_lit), .set_base(set_base),
        .base_word(base_word), .bundle_end(bundle_end),
        .branch_taken(branch_taken), .adv_field(adv_field),
        .phys_idx(phys_idx), .range_err(range_err), .wr_en(wr_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Expected mapping from the requirement formulas
    task automatic expect_map(input int m, input int r, output bit ok, output int idx);
        int s, loc;
        if (m == 0) begin
            ok  = (r < 64) && (r < 2 * m_wsz);
            idx = (r + 2 * m_wbs) % 224;
        end else begin
            s   = 2 * m_rsz + 2;
            ok  = (r < 128) && (r < 2 * m_wsz) && (r < s);
            loc = r + 2 * (m_rsz + 1 - m_rcur);
            loc = ((loc % s) + s) % s;
            idx = (loc + 2 * m_wbs + 2 * m_rbs) % 224;
        end
    endtask

    task automatic check_one(input string tag, input int m, input int r);
        bit ok; int idx;
        lreg_based = m[0]; lreg_num = r[6:0]; acc_valid = 1; acc_write = 1;
        #1;
        expect_map(m, r, ok, idx);
        chk({tag, " err/wr"}, {30'd0, range_err, wr_en}, ok ? 1 : 2);
        if (ok) chk({tag, " idx"}, phys_idx, idx);
    endtask

    // Sweep every register number in both modes
    task automatic sweep(input string tag);
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 128; r++)
                check_one(m == 0 ? {tag, "/R2"} : {tag, "/R4"}, m, r);
    endtask

    // One clock with the given commands; the model updates at the edge
    task automatic do_cycle(input bit sw, input int wb, input int wz,
                            input bit sb, input int rc, input int rz, input int rb,
                            input bit be, input bit br, input int adv);
        int step;
        @(negedge clk);
        set_win = sw; win_base = wb[6:0];
        win_lit = {20'hABCDE, wz[6:0], 5'h15};
        set_base = sb; base_word = {14'h2A5A, rc[5:0], rz[5:0], rb[5:0]};
        bundle_end = be; branch_taken = br; adv_field = adv[1:0];
        check_one("R9 old-state", 1, 1);
        @(posedge clk);
        if (sw) begin m_wbs = wb; m_wsz = wz; end
        if (sb) begin m_rcur = rc; m_rsz = rz; m_rbs = rb; end
        step = be ? (br ? (adv & 1) : ((adv >> 1) & 1)) : 0;
        if (step != 0) m_rcur = (m_rcur + 1) % (m_rsz + 1);
        @(negedge clk);
        set_win = 0; set_base = 0; bundle_end = 0; branch_taken = 0; adv_field = 0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R10: reset state: every access is out of range
        check_one("R10 reset", 0, 0);
        sweep("R10");
        // R8: idle and read-only accesses
        do_cycle(1, 5, 40, 1, 0, 4, 3, 0, 0, 0);
        acc_valid = 0; lreg_based = 0; lreg_num = 2; #1;
        chk("R8 idle", {30'd0, range_err, wr_en}, 0);
        acc_valid = 1; acc_write = 0; #1;
        chk("R8 read", {30'd0, range_err, wr_en}, 0);
        // R5 R6 R1: a spread of configurations, including maximum sums
        for (int c = 0; c < 10; c++) begin
            do_cycle(1, (c * 37 + 11) % 128, (c * 23 + 5) % 128, 1,
                     (c * 7) % 64, (c * 13 + 1) % 64, (c * 29) % 64, 0, 0, 0);
            sweep("R5/R6");
        end
        do_cycle(1, 127, 127, 1, 63, 63, 63, 0, 0, 0);
        sweep("R1 max");
        // R7 R3: rotation under every advance and branch combination
        do_cycle(1, 100, 60, 1, 0, 2, 40, 0, 0, 0);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < 3; k++) begin
                    do_cycle(0, 0, 0, 0, 0, 0, 0, 1, b[0], a);
                    sweep("R7/R3");
                end
        // R7: advance bits without bundle end do nothing
        do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        sweep("R7 hold");
        // R9: a load and an advance on the same edge
        do_cycle(0, 0, 0, 1, 1, 3, 7, 1, 0, 2);
        sweep("R9 combo");
        // R3: index loaded above the area size
        do_cycle(0, 0, 0, 1, 10, 3, 5, 0, 0, 0);
        sweep("R3 neg");
        do_cycle(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
        sweep("R3 neg-rot");
        // R10: reset in the middle of a run
        @(negedge clk); rst_n = 0;
        @(posedge clk); m_wbs = 0; m_wsz = 0; m_rbs = 0; m_rsz = 0; m_rcur = 0;
        @(negedge clk); rst_n = 1;
        sweep("R10 mid");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule